// File: doc/BRIEF.md
# Isochronous Receive Endpoint Controller

This block is the host-side control logic for one isochronous receive endpoint. Software programs four small registers: control/status, transfer type, service interval and interrupt enable. The block then asks an external token generator to send IN tokens to the target endpoint. A request comes either from a software write or, when DMA is in use, automatically after every received packet. Requests are paced by a slot counter that advances on frame-start pulses.

The packet engine reports each packet that lands in the receive FIFO. The block marks the packet ready and, depending on configuration, raises a DMA request or a level interrupt. It also produces a one-cycle unload strobe for an external drain path. The strobe fires either at packet arrival or at the next frame start, which lets a downstream sink take data at a steady frame rate.

Error events from the packet engine set a sticky flag, cancel any outstanding request and interrupt the host whatever the DMA setting. FIFO storage, the DMA engine and the token generator sit outside this block and connect through plain pulse and handshake ports.

Top module: `iso_rx_ep_ctrl`

## Requirements
- R1: After reset, tok_req, tok_ping, dma_req, irq and unload_strb are 0, and all registers read 0. Register reads are registered: reg_rdata shows the register at reg_addr one clock later. The addresses are 0 control/status, 1 type, 2 interval and 3 interrupt enable.
- R2: Writing control bit 5 as 1 sets a pending request that drives tok_req. Once raised, tok_req stays high until a cycle with tok_ack high, after which tok_req falls and control bit 5 reads 0.
- R3: A pkt_rx pulse sets the packet-ready flag (control bit 0). A fifo_drained pulse clears it, and so does a control write with bit 0 equal to 0. Arrival wins over a clear in the same cycle.
- R4: With DMA enable (control bit 13) set, dma_req is high one clock after the packet-ready flag is high, and it stays low while DMA enable is clear.
- R5: With DMA enable clear, a ready packet drives irq high. With DMA enable set, a ready packet alone never raises irq.
- R6: The auto-request field (control bits 9:8) set to 01 or 11, with DMA enabled, sets the pending request on every pkt_rx. Values 00 and 10, or DMA disabled, leave the request untouched.
- R7: No token request is raised while the packet-ready flag is set. The pending request is kept and goes out after the flag clears.
- R8: A token is requested only while the protocol field (type bits 5:4) equals 01. tok_ep carries type bits 3:0 and tok_speed carries type bits 7:6.
- R9: Each accepted token uses up one service slot. A new slot opens on the frame-start pulse that completes N frames, where N is the interval register and 0 counts as 1. Writing the interval restarts the frame count. The first slot after reset is already open.
- R10: An rx_err pulse sets the error flag (control bit 2), clears the pending request and tok_req, and raises irq one clock later if enabled, even with DMA set. Writing 1 to control bit 2 clears the flag.
- R11: tok_ping is 1 exactly when tok_speed is 10 (high speed) and the NYET-disable bit (control bit 12) is 0, updated one clock after a register write.
- R12: With DMA disabled, unload_strb pulses once per packet. With the frame-unload bit (control bit 15) clear, the pulse comes together with the ready flag on arrival. With it set, the pulse comes on the first sof_pulse that finds the packet ready. With DMA enabled it never pulses.
- R13: irq is forced low while bit 0 of the interrupt-enable register is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Registered read data for reg_addr |
| sof_pulse | input | 1 | Frame/microframe start pulse |
| tok_req | output | 1 | IN-token request to the token generator |
| tok_ack | input | 1 | Token generator accepted the request |
| tok_ep | output | EP_W | Target endpoint number |
| tok_speed | output | 2 | Operating speed code |
| tok_ping | output | 1 | PING flow control allowed |
| pkt_rx | input | 1 | A packet was written into the FIFO |
| rx_err | input | 1 | Transaction error event |
| fifo_drained | input | 1 | The FIFO was emptied by the drain path |
| dma_req | output | 1 | DMA service request |
| irq | output | 1 | Endpoint interrupt |
| unload_strb | output | 1 | Unload trigger for the drain path |

## Verification
The bench builds the block with INTV_W=4 and EP_W=4. The narrow interval counter puts both the zero-means-one mapping and a three-frame wrap within a few pulses, and the full endpoint field is carried to tok_ep. A table drives packet arrivals under seven combinations of DMA enable, auto-request code and interrupt enable, and checks irq, dma_req and the request bit. Directed runs cover the token handshake, slot pacing, protocol gating, hold-off while a packet is ready, error cancellation and both unload timings.

// File: rtl/iso_rx_pkg.sv
package iso_rx_pkg;
  localparam int REG_DW = 16;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_TYPE = 2'd1;
  localparam logic [1:0] A_INTV = 2'd2;
  localparam logic [1:0] A_IEN  = 2'd3;

  localparam int B_RDY   = 0;
  localparam int B_ERR   = 2;
  localparam int B_REQ   = 5;
  localparam int B_AUTO  = 8;
  localparam int B_DMODE = 11;
  localparam int B_NYET  = 12;
  localparam int B_DMAEN = 13;
  localparam int B_SOFU  = 15;

  localparam logic [1:0] PROTO_ISO = 2'b01;
  localparam logic [1:0] SPEED_HS  = 2'b10;

  typedef struct packed {
    logic       dma_en;
    logic       nyet_dis;
    logic       dma_mode;
    logic       sof_unload;
    logic [1:0] auto_req;
  } ep_cfg_t;
endpackage

// File: rtl/iso_rx_regs.sv
module iso_rx_regs
  import iso_rx_pkg::*;
#(
  parameter int INTV_W = 8,
  parameter int EP_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [1:0]        addr,
  input  logic [REG_DW-1:0] wdata,
  input  logic              st_rdy,
  input  logic              st_err,
  input  logic              st_req,
  output ep_cfg_t           cfg,
  output logic [1:0]        speed,
  output logic [1:0]        proto,
  output logic [EP_W-1:0]   ep,
  output logic [INTV_W-1:0] intv,
  output logic              intv_wr,
  output logic              irq_en,
  output logic              req_set,
  output logic              rdy_clr,
  output logic              err_clr,
  output logic              ping,
  output logic [REG_DW-1:0] rdata
);
  logic              ctrl_wr;
  logic [REG_DW-1:0] rd_mux;

  assign ctrl_wr = wr && (addr == A_CTRL);
  assign intv_wr = wr && (addr == A_INTV);
  assign req_set = ctrl_wr && wdata[B_REQ];
  assign rdy_clr = ctrl_wr && !wdata[B_RDY];
  assign err_clr = ctrl_wr && wdata[B_ERR];

  always_comb begin
    rd_mux = '0;
    case (addr)
      A_CTRL: begin
        rd_mux[B_RDY]            = st_rdy;
        rd_mux[B_ERR]            = st_err;
        rd_mux[B_REQ]            = st_req;
        rd_mux[B_AUTO+1:B_AUTO]  = cfg.auto_req;
        rd_mux[B_DMODE]          = cfg.dma_mode;
        rd_mux[B_NYET]           = cfg.nyet_dis;
        rd_mux[B_DMAEN]          = cfg.dma_en;
        rd_mux[B_SOFU]           = cfg.sof_unload;
      end
      A_TYPE: begin
        rd_mux[7:6]      = speed;
        rd_mux[5:4]      = proto;
        rd_mux[EP_W-1:0] = ep;
      end
      A_INTV:  rd_mux[INTV_W-1:0] = intv;
      default: rd_mux[0] = irq_en;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg    <= '0;
      speed  <= '0;
      proto  <= '0;
      ep     <= '0;
      intv   <= '0;
      irq_en <= 1'b0;
      ping   <= 1'b0;
      rdata  <= '0;
    end else begin
      if (wr) begin
        case (addr)
          A_CTRL: begin
            cfg.auto_req   <= wdata[B_AUTO+1:B_AUTO];
            cfg.dma_mode   <= wdata[B_DMODE];
            cfg.nyet_dis   <= wdata[B_NYET];
            cfg.dma_en     <= wdata[B_DMAEN];
            cfg.sof_unload <= wdata[B_SOFU];
          end
          A_TYPE: begin
            speed <= wdata[7:6];
            proto <= wdata[5:4];
            ep    <= wdata[EP_W-1:0];
          end
          A_INTV:  intv   <= wdata[INTV_W-1:0];
          default: irq_en <= wdata[0];
        endcase
      end
      ping  <= (speed == SPEED_HS) && !cfg.nyet_dis;
      rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/iso_rx_slot.sv
module iso_rx_slot #(
  parameter int INTV_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sof,
  input  logic [INTV_W-1:0] intv,
  input  logic              restart,
  input  logic              consume,
  output logic              slot_open
);
  logic [INTV_W-1:0] cnt;
  logic [INTV_W-1:0] last;
  logic              wrap;
  logic              open_n;

  assign last = (intv == '0) ? '0 : intv - 1'b1;
  assign wrap = sof && !restart && (cnt == last);

  always_comb begin
    open_n = consume ? 1'b0 : slot_open;
    if (wrap) open_n = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      slot_open <= 1'b1;
    end else begin
      if (restart)  cnt <= '0;
      else if (sof) cnt <= wrap ? '0 : cnt + 1'b1;
      slot_open <= open_n;
    end
  end
endmodule

// File: rtl/iso_rx_pkt.sv
module iso_rx_pkt
  import iso_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  ep_cfg_t    cfg,
  input  logic [1:0] proto,
  input  logic       irq_en,
  input  logic       slot_open,
  input  logic       pkt_rx,
  input  logic       rx_err,
  input  logic       fifo_drained,
  input  logic       sof,
  input  logic       tok_ack,
  input  logic       req_set,
  input  logic       rdy_clr,
  input  logic       err_clr,
  output logic       pkt_ready,
  output logic       err_flag,
  output logic       req_pend,
  output logic       tok_req,
  output logic       tok_fire,
  output logic       dma_req,
  output logic       irq,
  output logic       unload_strb
);
  logic auto_hit;
  logic req_n, tok_n, rdy_n, err_n;
  logic strb_n, strobed, strobed_n;

  assign tok_fire = tok_req && tok_ack;
  assign auto_hit = pkt_rx && cfg.dma_en && cfg.auto_req[0];

  always_comb begin
    if (rx_err)                  req_n = 1'b0;
    else if (req_set || auto_hit) req_n = 1'b1;
    else if (tok_fire)           req_n = 1'b0;
    else                         req_n = req_pend;

    if (rx_err)       tok_n = 1'b0;
    else if (tok_req) tok_n = !tok_ack;
    else              tok_n = req_pend && !pkt_ready && slot_open && (proto == PROTO_ISO);

    if (pkt_rx)                       rdy_n = 1'b1;
    else if (fifo_drained || rdy_clr) rdy_n = 1'b0;
    else                              rdy_n = pkt_ready;

    if (rx_err)       err_n = 1'b1;
    else if (err_clr) err_n = 1'b0;
    else              err_n = err_flag;

    strb_n = !cfg.dma_en &&
             (cfg.sof_unload ? (sof && pkt_ready && !strobed) : pkt_rx);
    strobed_n = rdy_n && (strobed || strb_n);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_pend    <= 1'b0;
      tok_req     <= 1'b0;
      pkt_ready   <= 1'b0;
      err_flag    <= 1'b0;
      dma_req     <= 1'b0;
      irq         <= 1'b0;
      unload_strb <= 1'b0;
      strobed     <= 1'b0;
    end else begin
      req_pend    <= req_n;
      tok_req     <= tok_n;
      pkt_ready   <= rdy_n;
      err_flag    <= err_n;
      dma_req     <= pkt_ready && cfg.dma_en;
      irq         <= irq_en && (err_flag || (pkt_ready && !cfg.dma_en));
      unload_strb <= strb_n;
      strobed     <= strobed_n;
    end
  end
endmodule

// File: rtl/iso_rx_ep_ctrl.sv
module iso_rx_ep_ctrl
  import iso_rx_pkg::*;
#(
  parameter int INTV_W = 8,
  parameter int EP_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [REG_DW-1:0] reg_wdata,
  output logic [REG_DW-1:0] reg_rdata,
  input  logic              sof_pulse,
  output logic              tok_req,
  input  logic              tok_ack,
  output logic [EP_W-1:0]   tok_ep,
  output logic [1:0]        tok_speed,
  output logic              tok_ping,
  input  logic              pkt_rx,
  input  logic              rx_err,
  input  logic              fifo_drained,
  output logic              dma_req,
  output logic              irq,
  output logic              unload_strb
);
  ep_cfg_t           cfg;
  logic [1:0]        proto;
  logic [INTV_W-1:0] intv;
  logic              intv_wr, irq_en, req_set, rdy_clr, err_clr;
  logic              pkt_ready, err_flag, req_pend, tok_fire, slot_open;
  logic              dma_en;

  assign dma_en = cfg.dma_en;

  iso_rx_regs #(.INTV_W(INTV_W), .EP_W(EP_W)) regs_i (
    .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .st_rdy(pkt_ready), .st_err(err_flag), .st_req(req_pend),
    .cfg(cfg), .speed(tok_speed), .proto(proto), .ep(tok_ep), .intv(intv),
    .intv_wr(intv_wr), .irq_en(irq_en), .req_set(req_set), .rdy_clr(rdy_clr),
    .err_clr(err_clr), .ping(tok_ping), .rdata(reg_rdata)
  );

  iso_rx_slot #(.INTV_W(INTV_W)) slot_i (
    .clk(clk), .rst(rst), .sof(sof_pulse), .intv(intv), .restart(intv_wr),
    .consume(tok_fire), .slot_open(slot_open)
  );

  iso_rx_pkt pkt_i (
    .clk(clk), .rst(rst), .cfg(cfg), .proto(proto), .irq_en(irq_en),
    .slot_open(slot_open), .pkt_rx(pkt_rx), .rx_err(rx_err),
    .fifo_drained(fifo_drained), .sof(sof_pulse), .tok_ack(tok_ack),
    .req_set(req_set), .rdy_clr(rdy_clr), .err_clr(err_clr),
    .pkt_ready(pkt_ready), .err_flag(err_flag), .req_pend(req_pend),
    .tok_req(tok_req), .tok_fire(tok_fire), .dma_req(dma_req), .irq(irq),
    .unload_strb(unload_strb)
  );
endmodule

// File: rtl/iso_rx_ep_chk.sv
module iso_rx_ep_chk (
  input logic       clk,
  input logic       rst,
  input logic       tok_req,
  input logic       tok_ack,
  input logic       rx_err,
  input logic       pkt_ready,
  input logic       dma_en,
  input logic       dma_req,
  input logic       err_flag,
  input logic       irq_en,
  input logic       irq,
  input logic       unload_strb,
  input logic [1:0] proto
);
  p_tok_hold_r2: assert property (@(posedge clk) disable iff (rst)
    tok_req && !tok_ack && !rx_err |=> tok_req);

  p_tok_drop_r2: assert property (@(posedge clk) disable iff (rst)
    tok_req && tok_ack |=> !tok_req);

  p_dma_req_r4: assert property (@(posedge clk) disable iff (rst)
    pkt_ready && dma_en |=> dma_req);

  p_ready_block_r7: assert property (@(posedge clk) disable iff (rst)
    pkt_ready && !tok_req |=> !tok_req);

  p_proto_gate_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(tok_req) |-> ($past(proto) == 2'b01));

  p_err_irq_r10: assert property (@(posedge clk) disable iff (rst)
    err_flag && irq_en |=> irq);

  p_unload_no_dma_r12: assert property (@(posedge clk) disable iff (rst)
    unload_strb |-> !$past(dma_en));
endmodule

bind iso_rx_ep_ctrl iso_rx_ep_chk chk_i (
  .clk(clk), .rst(rst), .tok_req(tok_req), .tok_ack(tok_ack), .rx_err(rx_err),
  .pkt_ready(pkt_ready), .dma_en(dma_en), .dma_req(dma_req),
  .err_flag(err_flag), .irq_en(irq_en), .irq(irq),
  .unload_strb(unload_strb), .proto(proto)
);

// File: tb/iso_rx_ep_ctrl_tb_top.sv
`timescale 1ns/1ps
module iso_rx_ep_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        sof_pulse = 1'b0;
  logic        tok_req, tok_ping, dma_req, irq, unload_strb;
  logic        tok_ack = 1'b0;
  logic [3:0]  tok_ep;
  logic [1:0]  tok_speed;
  logic        pkt_rx = 1'b0, rx_err = 1'b0, fifo_drained = 1'b0;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  iso_rx_ep_ctrl #(.INTV_W(4), .EP_W(4)) dut_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sof_pulse(sof_pulse),
    .tok_req(tok_req), .tok_ack(tok_ack), .tok_ep(tok_ep),
    .tok_speed(tok_speed), .tok_ping(tok_ping), .pkt_rx(pkt_rx),
    .rx_err(rx_err), .fifo_drained(fifo_drained), .dma_req(dma_req),
    .irq(irq), .unload_strb(unload_strb)
  );

  // fields: cfg word, irq enable, expected irq, expected dma_req, expected request bit
  localparam logic [19:0] VEC [0:6] = '{
    {16'h0000, 4'b1100},
    {16'h0000, 4'b0000},
    {16'h2000, 4'b1010},
    {16'h2100, 4'b1011},
    {16'h2300, 4'b1011},
    {16'h2200, 4'b1010},
    {16'h0100, 4'b1100}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 2'd0;
  endtask

  task automatic pulse_rx();   pkt_rx = 1'b1;       @(negedge clk); pkt_rx = 1'b0;       endtask
  task automatic pulse_err();  rx_err = 1'b1;       @(negedge clk); rx_err = 1'b0;       endtask
  task automatic pulse_drn();  fifo_drained = 1'b1; @(negedge clk); fifo_drained = 1'b0; endtask
  task automatic pulse_sof();  sof_pulse = 1'b1;    @(negedge clk); sof_pulse = 1'b0;    endtask
  task automatic pulse_ack();  tok_ack = 1'b1;      @(negedge clk); tok_ack = 1'b0;      endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    step(3);
    rst = 1'b0;
    step(1);
    // R1 reset state
    check("R1 tok_req", tok_req, 0);
    check("R1 irq", irq, 0);
    check("R1 dma_req", dma_req, 0);
    check("R1 unload", unload_strb, 0);
    check("R1 ping", tok_ping, 0);
    check("R1 ctrl read", reg_rdata, 0);

    // Table: R5, R6, R4, R13 (protocol is 00, so no tokens go out)
    for (int i = 0; i < 7; i++) begin
      wr(2'd3, {15'd0, VEC[i][3]});
      wr(2'd0, VEC[i][19:4]);
      pulse_rx();
      step(1);
      check($sformatf("R5/R13 irq vec%0d", i), irq, VEC[i][2]);
      check($sformatf("R4 dma_req vec%0d", i), dma_req, VEC[i][1]);
      check($sformatf("R6 req bit vec%0d", i), reg_rdata[5], VEC[i][0]);
      pulse_err();
      wr(2'd0, 16'h0004);
      step(2);
    end
    wr(2'd3, 16'h0000);

    // R2 / R8 token handshake and fields
    wr(2'd1, 16'h0095);
    wr(2'd2, 16'h0001);
    wr(2'd0, 16'h0020);
    step(1);
    check("R2 tok_req raised", tok_req, 1);
    check("R8 tok_ep", tok_ep, 5);
    check("R8 tok_speed", tok_speed, 2);
    step(3);
    check("R2 tok_req held", tok_req, 1);
    pulse_ack();
    check("R2 tok_req after ack", tok_req, 0);
    step(1);
    check("R2 req bit cleared", reg_rdata[5], 0);

    // R9 slot use, interval 1
    wr(2'd0, 16'h0020);
    step(2);
    check("R9 slot closed", tok_req, 0);
    pulse_sof();
    step(1);
    check("R9 slot reopened", tok_req, 1);
    pulse_ack();

    // R9 interval 3
    wr(2'd2, 16'h0003);
    wr(2'd0, 16'h0020);
    pulse_sof(); step(1);
    check("R9 int3 frame1", tok_req, 0);
    pulse_sof(); step(1);
    check("R9 int3 frame2", tok_req, 0);
    pulse_sof(); step(1);
    check("R9 int3 frame3", tok_req, 1);
    pulse_ack();

    // R9 interval 0 acts as 1
    wr(2'd2, 16'h0000);
    wr(2'd0, 16'h0020);
    pulse_sof(); step(1);
    check("R9 int0", tok_req, 1);
    pulse_ack();

    // R7 hold while ready, R3 set, R12 arrival strobe
    pulse_sof();
    pulse_rx();
    check("R12 arrival strobe", unload_strb, 1);
    wr(2'd0, 16'h0021);
    check("R12 strobe single", unload_strb, 0);
    step(3);
    check("R7 held while ready", tok_req, 0);
    check("R3 ready bit", reg_rdata[0], 1);
    pulse_drn();
    step(1);
    check("R7 released", tok_req, 1);
    check("R3 drained", reg_rdata[0], 0);
    pulse_ack();

    // R3 software clear
    pulse_rx();
    wr(2'd0, 16'h0000);
    step(1);
    check("R3 sw clear", reg_rdata[0], 0);

    // R8 protocol gating
    wr(2'd1, 16'h0085);
    pulse_sof();
    wr(2'd0, 16'h0020);
    step(3);
    check("R8 non-iso blocked", tok_req, 0);
    wr(2'd1, 16'h0095);
    step(1);
    check("R8 iso allowed", tok_req, 1);

    // R10 error
    wr(2'd3, 16'h0001);
    wr(2'd0, 16'h2020);
    pulse_err();
    check("R10 tok dropped", tok_req, 0);
    step(1);
    check("R10 irq with dma", irq, 1);
    check("R10 err bit", reg_rdata[2], 1);
    check("R10 req cleared", reg_rdata[5], 0);
    wr(2'd0, 16'h2004);
    step(1);
    check("R10 err cleared", reg_rdata[2], 0);
    check("R10 irq cleared", irq, 0);
    step(2);
    check("R10 no reissue", tok_req, 0);

    // R11 ping
    check("R11 hs ping", tok_ping, 1);
    wr(2'd0, 16'h1000); step(1);
    check("R11 nyet off", tok_ping, 0);
    wr(2'd0, 16'h0000);
    wr(2'd1, 16'h0055); step(1);
    check("R11 fs no ping", tok_ping, 0);
    wr(2'd1, 16'h0095); step(1);
    check("R11 hs again", tok_ping, 1);

    // R12 frame-aligned unload
    wr(2'd3, 16'h0000);
    wr(2'd0, 16'h8000);
    pulse_rx();
    check("R12 sof mode no arrival strobe", unload_strb, 0);
    step(2);
    check("R12 waits frame", unload_strb, 0);
    pulse_sof();
    check("R12 frame strobe", unload_strb, 1);
    step(1);
    check("R12 strobe one cycle", unload_strb, 0);
    pulse_sof();
    check("R12 once per packet", unload_strb, 0);
    pulse_drn();
    wr(2'd0, 16'hA000);
    pulse_rx();
    check("R12 dma no arrival strobe", unload_strb, 0);
    pulse_sof();
    check("R12 dma no frame strobe", unload_strb, 0);
    pulse_drn();
    step(2);

    done = 1'b1;
    finish_run();
  end
endmodule